// File: doc/BRIEF.md
# Unified Partitioned Physical Register File

This block stores the renamed register state of an out-of-order core. Integer, floating-point and condition-code registers live in three banks of independent size, yet every consumer addresses them through one flat physical index. The integer entries take the lowest indices. The floating-point entries start right after them, and the condition-code entries start after the floating-point ones. The block works out which class an index belongs to and turns it into an offset inside the matching bank.

Each class has one combinational read port and one clocked write port. A separate query port reports the class of any index. A floating-point entry can be written from a numeric-value input or from a raw-bit input, and it is read back on a value output and a raw-bit output. Both views use the same storage. One integer entry is the hardwired zero register, and writes to it are dropped. An access whose index falls outside the class of its port raises that port's error flag and does nothing else.

Top module: `prf_unified`

## Requirements
- R1: The query outputs mark index i as follows. Integer when i < INT_N. Floating-point when INT_N <= i < INT_N+FP_N. Condition-code when INT_N+FP_N <= i < INT_N+FP_N+CC_N.
- R2: The three query outputs are never high together, and all three are low for any index at or above INT_N+FP_N+CC_N.
- R3: Every index of a class maps to its own entry. A write to one index changes only the value read back at that same index. Floating-point and condition-code entries are addressed by their flat index, not by their bank offset.
- R4: A write to integer index ZERO_IDX is dropped and raises no error, so that index always reads 0.
- R5: A floating-point write stores fp_wr_bits_i when fp_wr_raw_i is 1 and fp_wr_val_i when it is 0. Both fp_rd_val_o and fp_rd_bits_o show the stored entry.
- R6: A read whose index lies outside the class of its port drives that port's read error high and its data to 0. A read with an in-class index keeps the error low.
- R7: An enabled write whose index lies outside the class of its port drives that port's write error high and leaves every entry unchanged.
- R8: Writes take effect on the rising clock edge and reads are combinational. A read of the index being written in the same cycle returns the old value until the edge, then the new value.
- R9: While rst_ni is low, every entry of every bank is cleared to 0.
- R10: With the write enable low, the write data and index inputs have no effect on storage, and the write error stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cls_idx_i | input | IDX_W | Index to classify |
| is_int_o | output | 1 | Query index is integer |
| is_fp_o | output | 1 | Query index is floating-point |
| is_cc_o | output | 1 | Query index is condition-code |
| int_rd_idx_i | input | IDX_W | Integer read index |
| int_rd_data_o | output | INT_W | Integer read data |
| int_rd_err_o | output | 1 | Integer read index out of class |
| int_wr_en_i | input | 1 | Integer write enable |
| int_wr_idx_i | input | IDX_W | Integer write index |
| int_wr_data_i | input | INT_W | Integer write data |
| int_wr_err_o | output | 1 | Integer write index out of class |
| fp_rd_idx_i | input | IDX_W | Floating-point read index |
| fp_rd_val_o | output | FP_W | Floating-point entry, value view |
| fp_rd_bits_o | output | FP_W | Floating-point entry, raw-bit view |
| fp_rd_err_o | output | 1 | Floating-point read index out of class |
| fp_wr_en_i | input | 1 | Floating-point write enable |
| fp_wr_raw_i | input | 1 | 1: store raw bits, 0: store value |
| fp_wr_idx_i | input | IDX_W | Floating-point write index |
| fp_wr_val_i | input | FP_W | Value-view write data |
| fp_wr_bits_i | input | FP_W | Raw-bit write data |
| fp_wr_err_o | output | 1 | Floating-point write index out of class |
| cc_rd_idx_i | input | IDX_W | Condition-code read index |
| cc_rd_data_o | output | CC_W | Condition-code read data |
| cc_rd_err_o | output | 1 | Condition-code read index out of class |
| cc_wr_en_i | input | 1 | Condition-code write enable |
| cc_wr_idx_i | input | IDX_W | Condition-code write index |
| cc_wr_data_i | input | CC_W | Condition-code write data |
| cc_wr_err_o | output | 1 | Condition-code write index out of class |

## Verification
The bench sweeps the query index across every bank boundary and past the total count. An off-by-one in a base comparison therefore shows up as a wrong or doubled class flag at the first or last index of a bank. It fills every entry of each bank with a distinct value. A design that forgot to subtract the class base, or subtracted the wrong one, would alias entries or read back zero. A write to the zero register, wrong-class writes and reads, and disabled writes are each followed by read-backs, which catch a design that stores anyway or leaks stale data through an error read. A read and a write to the same index in one cycle separate a write-through read from the required old-then-new timing.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_INT  = 2'd1,
    CLS_FP   = 2'd2,
    CLS_CC   = 2'd3
  } reg_class_e;
endpackage

// File: rtl/prf_class_dec.sv
module prf_class_dec #(
  parameter int INT_N = 8,
  parameter int FP_N  = 6,
  parameter int CC_N  = 4,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0]      idx_i,
  output prf_pkg::reg_class_e   cls_o,
  output logic [IDX_W-1:0]      off_o
);
  localparam int FP_BASE = INT_N;
  localparam int CC_BASE = INT_N + FP_N;
  localparam int TOTAL   = CC_BASE + CC_N;
  localparam logic [IDX_W:0] FP_BASE_L = (IDX_W+1)'(FP_BASE);
  localparam logic [IDX_W:0] CC_BASE_L = (IDX_W+1)'(CC_BASE);
  localparam logic [IDX_W:0] TOTAL_L   = (IDX_W+1)'(TOTAL);

  logic [IDX_W:0] idx_ext;
  logic [IDX_W:0] off_ext;

  assign idx_ext = {1'b0, idx_i};

  always_comb begin
    cls_o   = prf_pkg::CLS_NONE;
    off_ext = '0;
    if (idx_ext < FP_BASE_L) begin
      cls_o   = prf_pkg::CLS_INT;
      off_ext = idx_ext;
    end else if (idx_ext < CC_BASE_L) begin
      cls_o   = prf_pkg::CLS_FP;
      off_ext = idx_ext - FP_BASE_L;
    end else if (idx_ext < TOTAL_L) begin
      cls_o   = prf_pkg::CLS_CC;
      off_ext = idx_ext - CC_BASE_L;
    end
  end

  assign off_o = off_ext[IDX_W-1:0];
endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
  parameter int DEPTH    = 8,
  parameter int WIDTH    = 32,
  parameter int IDX_W    = 5,
  parameter bit HAS_ZERO = 1'b0,
  parameter int ZERO_OFF = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_off_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_off_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    if (HAS_ZERO && (e == ZERO_OFF)) begin : g_zero
      assign mem[e] = '0;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mem[e] <= '0;
        end else if (wr_en_i && (wr_off_i == IDX_W'(e))) begin
          mem[e] <= wr_data_i;
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_off_i == IDX_W'(e)) rd_data_o = mem[e];
    end
  end
endmodule

// File: rtl/prf_unified.sv
module prf_unified #(
  parameter int INT_N    = 8,
  parameter int FP_N     = 6,
  parameter int CC_N     = 4,
  parameter int INT_W    = 32,
  parameter int FP_W     = 32,
  parameter int CC_W     = 4,
  parameter int ZERO_IDX = 0,
  parameter int TOTAL    = INT_N + FP_N + CC_N,
  parameter int IDX_W    = $clog2(TOTAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] cls_idx_i,
  output logic             is_int_o,
  output logic             is_fp_o,
  output logic             is_cc_o,
  input  logic [IDX_W-1:0] int_rd_idx_i,
  output logic [INT_W-1:0] int_rd_data_o,
  output logic             int_rd_err_o,
  input  logic             int_wr_en_i,
  input  logic [IDX_W-1:0] int_wr_idx_i,
  input  logic [INT_W-1:0] int_wr_data_i,
  output logic             int_wr_err_o,
  input  logic [IDX_W-1:0] fp_rd_idx_i,
  output logic [FP_W-1:0]  fp_rd_val_o,
  output logic [FP_W-1:0]  fp_rd_bits_o,
  output logic             fp_rd_err_o,
  input  logic             fp_wr_en_i,
  input  logic             fp_wr_raw_i,
  input  logic [IDX_W-1:0] fp_wr_idx_i,
  input  logic [FP_W-1:0]  fp_wr_val_i,
  input  logic [FP_W-1:0]  fp_wr_bits_i,
  output logic             fp_wr_err_o,
  input  logic [IDX_W-1:0] cc_rd_idx_i,
  output logic [CC_W-1:0]  cc_rd_data_o,
  output logic             cc_rd_err_o,
  input  logic             cc_wr_en_i,
  input  logic [IDX_W-1:0] cc_wr_idx_i,
  input  logic [CC_W-1:0]  cc_wr_data_i,
  output logic             cc_wr_err_o
);
  import prf_pkg::*;

  localparam int NPORT = 7;
  localparam int P_Q   = 0;
  localparam int P_IR  = 1;
  localparam int P_IW  = 2;
  localparam int P_FR  = 3;
  localparam int P_FW  = 4;
  localparam int P_CR  = 5;
  localparam int P_CW  = 6;

  logic [IDX_W-1:0] dec_idx [NPORT];
  reg_class_e       dec_cls [NPORT];
  logic [IDX_W-1:0] dec_off [NPORT];

  assign dec_idx[P_Q]  = cls_idx_i;
  assign dec_idx[P_IR] = int_rd_idx_i;
  assign dec_idx[P_IW] = int_wr_idx_i;
  assign dec_idx[P_FR] = fp_rd_idx_i;
  assign dec_idx[P_FW] = fp_wr_idx_i;
  assign dec_idx[P_CR] = cc_rd_idx_i;
  assign dec_idx[P_CW] = cc_wr_idx_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    prf_class_dec #(
      .INT_N(INT_N), .FP_N(FP_N), .CC_N(CC_N), .IDX_W(IDX_W)
    ) u_dec (
      .idx_i(dec_idx[p]),
      .cls_o(dec_cls[p]),
      .off_o(dec_off[p])
    );
  end

  // class query
  assign is_int_o = (dec_cls[P_Q] == CLS_INT);
  assign is_fp_o  = (dec_cls[P_Q] == CLS_FP);
  assign is_cc_o  = (dec_cls[P_Q] == CLS_CC);

  // per-port class checks
  logic int_rd_ok, int_wr_ok, fp_rd_ok, fp_wr_ok, cc_rd_ok, cc_wr_ok;
  assign int_rd_ok = (dec_cls[P_IR] == CLS_INT);
  assign int_wr_ok = (dec_cls[P_IW] == CLS_INT);
  assign fp_rd_ok  = (dec_cls[P_FR] == CLS_FP);
  assign fp_wr_ok  = (dec_cls[P_FW] == CLS_FP);
  assign cc_rd_ok  = (dec_cls[P_CR] == CLS_CC);
  assign cc_wr_ok  = (dec_cls[P_CW] == CLS_CC);

  assign int_rd_err_o = ~int_rd_ok;
  assign fp_rd_err_o  = ~fp_rd_ok;
  assign cc_rd_err_o  = ~cc_rd_ok;
  assign int_wr_err_o = int_wr_en_i & ~int_wr_ok;
  assign fp_wr_err_o  = fp_wr_en_i  & ~fp_wr_ok;
  assign cc_wr_err_o  = cc_wr_en_i  & ~cc_wr_ok;

  // banks
  logic [INT_W-1:0] int_q;
  logic [FP_W-1:0]  fp_q;
  logic [CC_W-1:0]  cc_q;
  logic [FP_W-1:0]  fp_wdata;

  assign fp_wdata = fp_wr_raw_i ? fp_wr_bits_i : fp_wr_val_i;

  prf_bank #(
    .DEPTH(INT_N), .WIDTH(INT_W), .IDX_W(IDX_W),
    .HAS_ZERO(1'b1), .ZERO_OFF(ZERO_IDX)
  ) u_int_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(int_wr_en_i & int_wr_ok),
    .wr_off_i(dec_off[P_IW]),
    .wr_data_i(int_wr_data_i),
    .rd_off_i(dec_off[P_IR]),
    .rd_data_o(int_q)
  );

  prf_bank #(
    .DEPTH(FP_N), .WIDTH(FP_W), .IDX_W(IDX_W),
    .HAS_ZERO(1'b0), .ZERO_OFF(0)
  ) u_fp_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(fp_wr_en_i & fp_wr_ok),
    .wr_off_i(dec_off[P_FW]),
    .wr_data_i(fp_wdata),
    .rd_off_i(dec_off[P_FR]),
    .rd_data_o(fp_q)
  );

  prf_bank #(
    .DEPTH(CC_N), .WIDTH(CC_W), .IDX_W(IDX_W),
    .HAS_ZERO(1'b0), .ZERO_OFF(0)
  ) u_cc_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(cc_wr_en_i & cc_wr_ok),
    .wr_off_i(dec_off[P_CW]),
    .wr_data_i(cc_wr_data_i),
    .rd_off_i(dec_off[P_CR]),
    .rd_data_o(cc_q)
  );

  assign int_rd_data_o = int_rd_ok ? int_q : '0;
  assign fp_rd_val_o   = fp_rd_ok  ? fp_q  : '0;
  assign fp_rd_bits_o  = fp_rd_ok  ? fp_q  : '0;
  assign cc_rd_data_o  = cc_rd_ok  ? cc_q  : '0;
endmodule

// File: rtl/prf_unified_chk.sv
module prf_unified_chk #(
  parameter int INT_N    = 8,
  parameter int FP_N     = 6,
  parameter int CC_N     = 4,
  parameter int INT_W    = 32,
  parameter int FP_W     = 32,
  parameter int CC_W     = 4,
  parameter int ZERO_IDX = 0,
  parameter int TOTAL    = INT_N + FP_N + CC_N,
  parameter int IDX_W    = $clog2(TOTAL + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] cls_idx_i,
  input logic             is_int_o,
  input logic             is_fp_o,
  input logic             is_cc_o,
  input logic [IDX_W-1:0] int_rd_idx_i,
  input logic [INT_W-1:0] int_rd_data_o,
  input logic             int_rd_err_o,
  input logic             int_wr_en_i,
  input logic [IDX_W-1:0] int_wr_idx_i,
  input logic [INT_W-1:0] int_wr_data_i,
  input logic             int_wr_err_o,
  input logic [FP_W-1:0]  fp_rd_val_o,
  input logic             fp_rd_err_o,
  input logic             fp_wr_en_i,
  input logic [IDX_W-1:0] fp_wr_idx_i,
  input logic             fp_wr_err_o
);
  localparam logic [IDX_W:0] FP_BASE_L = (IDX_W+1)'(INT_N);
  localparam logic [IDX_W:0] CC_BASE_L = (IDX_W+1)'(INT_N + FP_N);
  localparam logic [IDX_W:0] TOTAL_L   = (IDX_W+1)'(TOTAL);
  localparam logic [IDX_W-1:0] ZERO_L  = IDX_W'(ZERO_IDX);

  a_r2_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({is_int_o, is_fp_o, is_cc_o}));

  a_r2_beyond_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cls_idx_i} >= TOTAL_L) |-> !(is_int_o || is_fp_o || is_cc_o));

  a_r1_fp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (({1'b0, cls_idx_i} >= FP_BASE_L) && ({1'b0, cls_idx_i} < CC_BASE_L)) |-> is_fp_o);

  a_r4_zero_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rd_idx_i == ZERO_L) |-> (int_rd_data_o == '0));

  a_r6_int_err_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rd_err_o |-> (int_rd_data_o == '0));

  a_r6_fp_err_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_rd_err_o |-> (fp_rd_val_o == '0));

  a_r7_fp_wr_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_wr_en_i && (({1'b0, fp_wr_idx_i} < FP_BASE_L) || ({1'b0, fp_wr_idx_i} >= CC_BASE_L)))
      |-> fp_wr_err_o);

  a_r10_no_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_wr_en_i |-> !int_wr_err_o);

  a_r8_int_wr_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_wr_en_i && !int_wr_err_o && (int_wr_idx_i != ZERO_L))
      |=> ((int_rd_idx_i != $past(int_wr_idx_i)) || (int_rd_data_o == $past(int_wr_data_i))));
endmodule

bind prf_unified prf_unified_chk #(
  .INT_N(INT_N), .FP_N(FP_N), .CC_N(CC_N), .INT_W(INT_W), .FP_W(FP_W),
  .CC_W(CC_W), .ZERO_IDX(ZERO_IDX), .TOTAL(TOTAL), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cls_idx_i(cls_idx_i),
  .is_int_o(is_int_o), .is_fp_o(is_fp_o), .is_cc_o(is_cc_o),
  .int_rd_idx_i(int_rd_idx_i), .int_rd_data_o(int_rd_data_o), .int_rd_err_o(int_rd_err_o),
  .int_wr_en_i(int_wr_en_i), .int_wr_idx_i(int_wr_idx_i), .int_wr_data_i(int_wr_data_i),
  .int_wr_err_o(int_wr_err_o), .fp_rd_val_o(fp_rd_val_o), .fp_rd_err_o(fp_rd_err_o),
  .fp_wr_en_i(fp_wr_en_i), .fp_wr_idx_i(fp_wr_idx_i), .fp_wr_err_o(fp_wr_err_o)
);

// File: tb/prf_unified_bench.sv
module prf_unified_bench;
  localparam int INT_N = 8, FP_N = 6, CC_N = 4;
  localparam int TOTAL = INT_N + FP_N + CC_N;
  localparam int IDX_W = 5;
  localparam int ZERO_IDX = 0;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [IDX_W-1:0] cls_idx_i = '0;
  logic is_int_o, is_fp_o, is_cc_o;
  logic [IDX_W-1:0] int_rd_idx_i = '0, int_wr_idx_i = '0;
  logic [31:0] int_rd_data_o, int_wr_data_i = '0;
  logic int_rd_err_o, int_wr_err_o, int_wr_en_i = 1'b0;
  logic [IDX_W-1:0] fp_rd_idx_i = '0, fp_wr_idx_i = '0;
  logic [31:0] fp_rd_val_o, fp_rd_bits_o, fp_wr_val_i = '0, fp_wr_bits_i = '0;
  logic fp_rd_err_o, fp_wr_err_o, fp_wr_en_i = 1'b0, fp_wr_raw_i = 1'b0;
  logic [IDX_W-1:0] cc_rd_idx_i = '0, cc_wr_idx_i = '0;
  logic [3:0] cc_rd_data_o, cc_wr_data_i = '0;
  logic cc_rd_err_o, cc_wr_err_o, cc_wr_en_i = 1'b0;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  prf_unified #(.INT_N(INT_N), .FP_N(FP_N), .CC_N(CC_N), .INT_W(32), .FP_W(32),
                .CC_W(4), .ZERO_IDX(ZERO_IDX)) u_prf_unified (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_int(input int idx, input logic [31:0] d);
    @(negedge clk_i);
    int_wr_en_i = 1'b1; int_wr_idx_i = IDX_W'(idx); int_wr_data_i = d;
    @(negedge clk_i);
    int_wr_en_i = 1'b0;
  endtask

  task automatic wr_fp(input int idx, input logic raw, input logic [31:0] v, input logic [31:0] b);
    @(negedge clk_i);
    fp_wr_en_i = 1'b1; fp_wr_raw_i = raw; fp_wr_idx_i = IDX_W'(idx);
    fp_wr_val_i = v; fp_wr_bits_i = b;
    @(negedge clk_i);
    fp_wr_en_i = 1'b0;
  endtask

  task automatic wr_cc(input int idx, input logic [3:0] d);
    @(negedge clk_i);
    cc_wr_en_i = 1'b1; cc_wr_idx_i = IDX_W'(idx); cc_wr_data_i = d;
    @(negedge clk_i);
    cc_wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < INT_N; i++) begin
      int_rd_idx_i = IDX_W'(i); #1;
      check("R9 int reset", int_rd_data_o, 32'h0);
    end
    for (int i = INT_N; i < INT_N + FP_N; i++) begin
      fp_rd_idx_i = IDX_W'(i); #1;
      check("R9 fp reset", fp_rd_val_o, 32'h0);
    end
    for (int i = INT_N + FP_N; i < TOTAL; i++) begin
      cc_rd_idx_i = IDX_W'(i); #1;
      check("R9 cc reset", {28'h0, cc_rd_data_o}, 32'h0);
    end
  endtask

  task automatic t_classes();
    for (int i = 0; i < 32; i++) begin
      logic ei, ef, ec;
      ei = (i < INT_N);
      ef = (i >= INT_N) && (i < INT_N + FP_N);
      ec = (i >= INT_N + FP_N) && (i < TOTAL);
      cls_idx_i = IDX_W'(i); #1;
      check(i < TOTAL ? "R1 class flags" : "R2 beyond total",
            {29'h0, is_int_o, is_fp_o, is_cc_o}, {29'h0, ei, ef, ec});
    end
  endtask

  task automatic t_fill();
    for (int i = 0; i < INT_N; i++) wr_int(i, 32'hA000_0000 + i);
    for (int i = INT_N; i < INT_N + FP_N; i++) wr_fp(i, 1'b0, 32'hF000_0000 + i, 32'h0);
    for (int i = INT_N + FP_N; i < TOTAL; i++) wr_cc(i, 4'(i + 3));
    @(negedge clk_i);
    for (int i = 0; i < INT_N; i++) begin
      int_rd_idx_i = IDX_W'(i); #1;
      if (i == ZERO_IDX) check("R4 zero reg", int_rd_data_o, 32'h0);
      else               check("R3 int entry", int_rd_data_o, 32'hA000_0000 + i);
    end
    for (int i = INT_N; i < INT_N + FP_N; i++) begin
      fp_rd_idx_i = IDX_W'(i); #1;
      check("R3 fp entry", fp_rd_val_o, 32'hF000_0000 + i);
      check("R6 fp err low", {31'h0, fp_rd_err_o}, 32'h0);
    end
    for (int i = INT_N + FP_N; i < TOTAL; i++) begin
      cc_rd_idx_i = IDX_W'(i); #1;
      check("R3 cc entry", {28'h0, cc_rd_data_o}, {28'h0, 4'(i + 3)});
    end
  endtask

  task automatic t_zero();
    @(negedge clk_i);
    int_wr_en_i = 1'b1; int_wr_idx_i = IDX_W'(ZERO_IDX); int_wr_data_i = 32'hDEAD_BEEF; #1;
    check("R4 zero write no err", {31'h0, int_wr_err_o}, 32'h0);
    @(negedge clk_i);
    int_wr_en_i = 1'b0; int_rd_idx_i = IDX_W'(ZERO_IDX); #1;
    check("R4 zero stays zero", int_rd_data_o, 32'h0);
  endtask

  task automatic t_fp_views();
    wr_fp(INT_N + 2, 1'b1, 32'h1111_1111, 32'h3F80_0000);
    fp_rd_idx_i = IDX_W'(INT_N + 2); #1;
    check("R5 raw write val view", fp_rd_val_o, 32'h3F80_0000);
    check("R5 raw write bits view", fp_rd_bits_o, 32'h3F80_0000);
    wr_fp(INT_N + 2, 1'b0, 32'h4000_0000, 32'h2222_2222);
    fp_rd_idx_i = IDX_W'(INT_N + 2); #1;
    check("R5 val write bits view", fp_rd_bits_o, 32'h4000_0000);
  endtask

  task automatic t_wrong_class();
    int_rd_idx_i = IDX_W'(INT_N + 1); #1;
    check("R6 int rd err", {31'h0, int_rd_err_o}, 32'h1);
    check("R6 int rd data zero", int_rd_data_o, 32'h0);
    cc_rd_idx_i = IDX_W'(TOTAL); #1;
    check("R6 cc rd beyond err", {31'h0, cc_rd_err_o}, 32'h1);
    @(negedge clk_i);
    fp_wr_en_i = 1'b1; fp_wr_raw_i = 1'b0; fp_wr_idx_i = IDX_W'(3); fp_wr_val_i = 32'h5555_5555; #1;
    check("R7 fp wr err", {31'h0, fp_wr_err_o}, 32'h1);
    @(negedge clk_i);
    fp_wr_en_i = 1'b0;
    cc_wr_en_i = 1'b1; cc_wr_idx_i = IDX_W'(INT_N + 1); cc_wr_data_i = 4'hF; #1;
    check("R7 cc wr err", {31'h0, cc_wr_err_o}, 32'h1);
    @(negedge clk_i);
    cc_wr_en_i = 1'b0;
    int_rd_idx_i = IDX_W'(3); fp_rd_idx_i = IDX_W'(INT_N + 1); #1;
    check("R7 int entry kept", int_rd_data_o, 32'hA000_0003);
    check("R7 fp entry kept", fp_rd_val_o, 32'hF000_0000 + INT_N + 1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    int_wr_en_i = 1'b1; int_wr_idx_i = IDX_W'(5); int_wr_data_i = 32'h0BAD_F00D;
    int_rd_idx_i = IDX_W'(5); #1;
    check("R8 old before edge", int_rd_data_o, 32'hA000_0005);
    @(negedge clk_i);
    int_wr_en_i = 1'b0; #1;
    check("R8 new after edge", int_rd_data_o, 32'h0BAD_F00D);
  endtask

  task automatic t_disabled();
    @(negedge clk_i);
    cc_wr_en_i = 1'b0; cc_wr_idx_i = IDX_W'(INT_N + FP_N); cc_wr_data_i = 4'h9;
    int_wr_en_i = 1'b0; int_wr_idx_i = IDX_W'(20); #1;
    check("R10 no err when idle", {31'h0, int_wr_err_o}, 32'h0);
    @(negedge clk_i);
    cc_rd_idx_i = IDX_W'(INT_N + FP_N); #1;
    check("R10 cc unchanged", {28'h0, cc_rd_data_o}, {28'h0, 4'(INT_N + FP_N + 3)});
  endtask

  task automatic t_reset_again();
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    int_rd_idx_i = IDX_W'(5); fp_rd_idx_i = IDX_W'(INT_N + 2); #1;
    check("R9 int cleared", int_rd_data_o, 32'h0);
    check("R9 fp cleared", fp_rd_bits_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_classes();
    t_fill();
    t_zero();
    t_fp_views();
    t_wrong_class();
    t_same_cycle();
    t_disabled();
    t_reset_again();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule